// File: doc/BRIEF.md
# Bit-Serial Single-Error-Correcting Cyclic Decoder (7,4)

This block decodes words of a binary (7,4) cyclic code, length 7 and minimum distance 3, one bit per clock. The generator polynomial is g(x) = 1 + x + x^3. A received word is shifted in starting with the coefficient of x^6. Each bit goes into a 3-stage division register that forms the remainder of the received polynomial by g(x), and into a 7-bit holding register at the same time. Both registers start the word at zero.

After the seventh bit the input side closes and the block runs seven correction shifts. A single match gate compares the remainder register against one pattern, the remainder of x^6. A match means that the bit now leaving the holding register is wrong. That bit is then inverted on its way out, and the match is also fed back into the division register. Each shift multiplies the remainder by x, so an error in any position reaches the match pattern exactly when its bit leaves the holding register. No table of syndromes is needed. The corrected bits leave with a valid flag, and the last beat is marked. An error flag reports a remainder that is still non-zero after the final shift.

Top module: `meggitt_decoder`

## Requirements
- R1: During reset and until two clock edges after `rst_n` is released, `in_ready` is 0. After that `in_ready` is 1, and `out_valid`, `out_last` and `out_err` are 0.
- R2: While `in_ready` is 1, every clock edge with `in_valid` 1 accepts `in_bit`. The first accepted bit of a word is the coefficient of x^6 and the seventh is the coefficient of x^0. After the seventh accepted bit, `in_ready` is 0 for the next seven cycles.
- R3: The first output beat is registered on the clock edge after the one that accepts the seventh bit. `out_valid` is then 1 for exactly seven consecutive cycles, and the beats carry the coefficients of x^6 down to x^0 in that order.
- R4: A received word that is a codeword (a multiple of 1 + x + x^3) is output unchanged.
- R5: A received word that differs from a codeword in exactly one of the seven positions is output as that codeword.
- R6: The remainder register holds the received polynomial modulo g(x), with bit i the coefficient of x^i. The detector fires only on (bit0, bit1, bit2) = (1, 0, 1). As a result, an error in the x^6 position is corrected on the first beat.
- R7: Within the correction phase, once the remainder register is zero it stays zero on every later shift, and it is zero on the shift after a detector match.
- R8: `out_last` is 1 on the seventh beat only. `out_err` can be 1 only on that beat, and it is 1 exactly when the remainder after the final shift is non-zero. Because every non-zero remainder of this code matches a single-error position, a word with two errors comes out as its nearest codeword with `out_err` 0.
- R9: While `in_ready` is 0, `in_valid` and `in_bit` have no effect on the outputs or on the next word.
- R10: The remainder register and the holding register are zero at the start of every word, so a word decodes the same regardless of the word before it.
- R11: Cycles with `in_valid` 0 during loading pause the load without changing the word that is gathered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Received bit present on `in_bit` |
| in_bit | input | 1 | Received bit, highest-order coefficient first |
| in_ready | output | 1 | Block is in the load phase and will accept a bit |
| out_valid | output | 1 | Corrected bit present on `out_bit` |
| out_bit | output | 1 | Corrected bit, highest-order coefficient first |
| out_last | output | 1 | Marks the seventh output beat |
| out_err | output | 1 | Remainder still non-zero after the final shift, valid with `out_last` |

## Verification
A bit is accepted on the rising edge where `in_valid` and `in_ready` are both 1. The bench drives inputs and reads outputs on falling edges. At the falling edge right after the seventh accept, it expects `in_ready` and `out_valid` both 0. It then expects the seven beats on the next seven falling edges, with `out_last`, `out_err` and the return of `in_ready` all on the seventh. The expected words come from a brute-force nearest-codeword search over the sixteen codewords built by polynomial multiplication in the bench. The bench also drives gapped input and stray input during correction, and it compares the output at those same fixed offsets.

// File: rtl/meggitt_pkg.sv
package meggitt_pkg;

  typedef enum logic [0:0] {
    PH_LOAD = 1'b0,
    PH_CORR = 1'b1
  } phase_e;

  // Remainder of x^pw divided by a generator of degree deg (bit i = coeff of x^i).
  function automatic logic [31:0] xpow_mod(input int unsigned pw,
                                           input int unsigned deg,
                                           input logic [31:0] gen);
    logic [31:0] acc;
    logic [31:0] mask;
    logic        top;
    mask = (32'd1 << deg) - 32'd1;
    acc  = 32'd1;
    for (int unsigned i = 0; i < pw; i++) begin
      top = acc[deg-1];
      acc = (acc << 1) & mask;
      if (top) acc = acc ^ (gen & mask);
    end
    return acc;
  endfunction

endpackage

// File: rtl/mg_control.sv
module mg_control
  import meggitt_pkg::*;
#(
  parameter int unsigned N = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic rst_sync_n,
  output logic in_ready,
  output logic load_step,
  output logic corr_step,
  output logic corr_last
);

  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(N - 1);

  logic [1:0]    rs_q;
  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  // reset synchroniser: asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  assign in_ready  = rst_sync_n && (phase_q == PH_LOAD);
  assign load_step = in_ready && in_valid;
  assign corr_step = (phase_q == PH_CORR);
  assign corr_last = corr_step && (cnt_q == CNT_TOP);
  assign cnt_en    = load_step || corr_step;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (cnt_en) begin
      if (cnt_q == CNT_TOP) begin
        cnt_d   = '0;
        phase_d = corr_step ? PH_LOAD : PH_CORR;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      phase_q <= PH_LOAD;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_q <= CNT_TOP);  // R3
  AST_LOAD_CLOSES: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_step && cnt_q == CNT_TOP) |=> (corr_step && !in_ready));  // R2
  AST_CORR_REOPENS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    corr_last |=> in_ready);  // R3
  AST_CORR_RUNS_ON: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corr_step && !corr_last) |=> corr_step);  // R3

endmodule

// File: rtl/mg_syndrome.sv
module mg_syndrome #(
  parameter int unsigned R   = 3,
  parameter logic [R:0]  GEN = 4'b1011
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         din,
  output logic [R-1:0] syn_q,
  output logic [R-1:0] syn_shift
);

  logic [R-1:0] syn_d;
  logic         fb;

  assign fb = syn_q[R-1];

  // division by the generator: multiply by x, add din at the low end, reduce
  for (genvar i = 0; i < R; i++) begin : g_stage
    if (i == 0) begin : g_low
      assign syn_shift[0] = din ^ fb;
    end else if (GEN[i]) begin : g_tap
      assign syn_shift[i] = syn_q[i-1] ^ fb;
    end else begin : g_plain
      assign syn_shift[i] = syn_q[i-1];
    end
  end

  always_comb begin
    syn_d = syn_q;
    if (clr)       syn_d = '0;
    else if (step) syn_d = syn_shift;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             syn_q <= '0;
    else if (clr || step)   syn_q <= syn_d;
  end

  AST_SYN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (syn_q == '0));  // R10
  AST_SYN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(syn_q));  // R11

endmodule

// File: rtl/mg_buffer.sv
module mg_buffer #(
  parameter int unsigned N = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  logic din,
  output logic head
);

  logic [N-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (clr)       data_d = '0;
    else if (step) data_d = {data_q[N-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           data_q <= '0;
    else if (clr || step) data_q <= data_d;
  end

  assign head = data_q[N-1];

  AST_BUF_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (data_q == '0));  // R10
  AST_BUF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(data_q));  // R11

endmodule

// File: rtl/mg_detector.sv
module mg_detector #(
  parameter int unsigned  R   = 3,
  parameter logic [R-1:0] PAT = 3'b101
) (
  input  logic [R-1:0] syn,
  output logic         hit
);

  logic [R-1:0] term;

  // one literal per stage: true or inverted, then a single R-input AND
  for (genvar i = 0; i < R; i++) begin : g_lit
    if (PAT[i]) begin : g_true
      assign term[i] = syn[i];
    end else begin : g_inv
      assign term[i] = ~syn[i];
    end
  end

  assign hit = &term;

endmodule

// File: rtl/meggitt_decoder.sv
module meggitt_decoder
  import meggitt_pkg::*;
#(
  parameter int unsigned N   = 7,
  parameter int unsigned R   = 3,
  parameter logic [R:0]  GEN = 4'b1011
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_bit,
  output logic in_ready,
  output logic out_valid,
  output logic out_bit,
  output logic out_last,
  output logic out_err
);

  localparam logic [31:0]  PAT_W = xpow_mod(N - 1, R, 32'(GEN));
  localparam logic [R-1:0] PAT   = PAT_W[R-1:0];

  logic         rst_sync_n;
  logic         load_step, corr_step, corr_last;
  logic         hit, head;
  logic         syn_din, syn_step, buf_din, buf_step;
  logic [R-1:0] syn_q, syn_shift;

  logic out_valid_q, out_valid_d;
  logic out_bit_q,   out_bit_d;
  logic out_last_q,  out_last_d;
  logic out_err_q,   out_err_d;

  mg_control #(.N(N)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .rst_sync_n (rst_sync_n),
    .in_ready   (in_ready),
    .load_step  (load_step),
    .corr_step  (corr_step),
    .corr_last  (corr_last)
  );

  // load: data enters at the left end; correct: detector output is fed back
  assign syn_din  = load_step ? in_bit : hit;
  assign syn_step = load_step || corr_step;
  assign buf_din  = load_step ? in_bit : 1'b0;
  assign buf_step = load_step || corr_step;

  mg_syndrome #(.R(R), .GEN(GEN)) u_syn (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clr       (corr_last),
    .step      (syn_step),
    .din       (syn_din),
    .syn_q     (syn_q),
    .syn_shift (syn_shift)
  );

  mg_buffer #(.N(N)) u_buf (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (corr_last),
    .step  (buf_step),
    .din   (buf_din),
    .head  (head)
  );

  mg_detector #(.R(R), .PAT(PAT)) u_det (
    .syn (syn_q),
    .hit (hit)
  );

  always_comb begin
    out_valid_d = corr_step;
    out_bit_d   = corr_step ? (head ^ hit) : 1'b0;
    out_last_d  = corr_last;
    out_err_d   = corr_last && (syn_shift != '0);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid_q <= 1'b0;
      out_bit_q   <= 1'b0;
      out_last_q  <= 1'b0;
      out_err_q   <= 1'b0;
    end else begin
      out_valid_q <= out_valid_d;
      out_bit_q   <= out_bit_d;
      out_last_q  <= out_last_d;
      out_err_q   <= out_err_d;
    end
  end

  assign out_valid = out_valid_q;
  assign out_bit   = out_bit_q;
  assign out_last  = out_last_q;
  assign out_err   = out_err_q;

  AST_HIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corr_step && hit) |=> (syn_q == '0));  // R7
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (corr_step && !corr_last && syn_q == '0) |=> (syn_q == '0));  // R7
  AST_ERR_ON_LAST: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_err |-> out_last);  // R8
  AST_LAST_IS_BEAT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_last |-> out_valid);  // R8
  AST_NO_BEAT_WHILE_READY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> $past(corr_step));  // R3
  AST_DET_ONEHOT_HIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    hit |-> (syn_q != '0));  // R6

endmodule

// File: tb/meggitt_decoder_bench.sv
`timescale 1ns/1ps
module meggitt_decoder_bench;

  logic clk = 1'b0;
  logic rst_n, in_valid, in_bit;
  logic in_ready, out_valid, out_bit, out_last, out_err;
  int   checks = 0;
  int   errors = 0;
  bit   fin = 1'b0;

  always #2 clk = ~clk;

  meggitt_decoder u_meggitt_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .out_valid(out_valid), .out_bit(out_bit),
    .out_last(out_last), .out_err(out_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // codeword of message m: m(x) * (1 + x + x^3), bit i = coeff of x^i
  function automatic logic [6:0] encode(input logic [3:0] m);
    logic [6:0] c = '0;
    for (int i = 0; i < 4; i++)
      if (m[i]) c = c ^ (7'b0001011 << i);
    return c;
  endfunction

  function automatic logic [6:0] nearest(input logic [6:0] rx);
    logic [6:0] best = '0;
    int         bd = 99;
    for (int m = 0; m < 16; m++) begin
      logic [6:0] c = encode(4'(m));
      if ($countones(c ^ rx) < bd) begin
        bd = $countones(c ^ rx);
        best = c;
      end
    end
    return best;
  endfunction

  // drive one word, then check its timing and its seven corrected beats
  task automatic run_word(input logic [6:0] rx, input int gap, input bit junk,
                          input string req);
    logic [6:0] got = '0;
    logic [6:0] exp = nearest(rx);
    while (!in_ready) @(negedge clk);
    for (int i = 6; i >= 0; i--) begin
      in_valid = 1'b1;
      in_bit   = rx[i];
      @(negedge clk);
      if (i > 0) begin
        for (int g = 0; g < gap; g++) begin
          in_valid = 1'b0;
          in_bit   = ~rx[i-1];
          @(negedge clk);
          chk("R11 ready held during gap", 32'(in_ready), 32'd1);
        end
      end
    end
    in_valid = junk;
    in_bit   = junk;
    chk("R2 ready low after seventh bit", 32'(in_ready), 32'd0);
    chk("R3 no beat yet", 32'(out_valid), 32'd0);
    for (int k = 0; k < 7; k++) begin
      if (junk) in_bit = ~in_bit;
      @(negedge clk);
      chk("R3 beat valid", 32'(out_valid), 32'd1);
      got[6-k] = out_bit;
      chk("R8 last marker", 32'(out_last), 32'(k == 6));
      if (k == 0 && (rx ^ exp) == 7'b1000000)
        chk("R6 x^6 error fixed on first beat", 32'(out_bit), 32'(exp[6]));
    end
    in_valid = 1'b0;
    chk("R8 err flag", 32'(out_err), 32'd0);
    chk("R3 ready back with last beat", 32'(in_ready), 32'd1);
    chk(req, 32'(got), 32'(exp));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_bit = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready low in reset", 32'(in_ready), 32'd0);
    chk("R1 valid low in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 ready after release", 32'(in_ready), 32'd1);
    chk("R1 valid idle", 32'(out_valid), 32'd0);
    chk("R1 last idle", 32'(out_last), 32'd0);
    chk("R1 err idle", 32'(out_err), 32'd0);
  endtask

  task automatic t_clean();
    for (int m = 0; m < 16; m++) run_word(encode(4'(m)), 0, 1'b0, "R4 codeword unchanged");
  endtask

  task automatic t_single();
    // words follow each other directly, so this also covers R10
    for (int m = 1; m < 16; m += 5)
      for (int p = 0; p < 7; p++)
        run_word(encode(4'(m)) ^ (7'd1 << p), 0, 1'b0, "R5 single error corrected");
    run_word(7'b1000000, 0, 1'b0, "R6 lone x^6 bit to zero word");
  endtask

  task automatic t_double();
    run_word(encode(4'd9) ^ 7'b0000011, 0, 1'b0, "R8 double error to nearest");
    run_word(encode(4'd4) ^ 7'b1000100, 0, 1'b0, "R8 double error to nearest");
    run_word(encode(4'd4), 0, 1'b0, "R10 clean word after miscorrection");
  endtask

  task automatic t_gaps();
    run_word(encode(4'd11) ^ 7'b0010000, 2, 1'b0, "R11 gapped load");
    run_word(encode(4'd3), 1, 1'b0, "R11 gapped clean load");
  endtask

  task automatic t_junk();
    run_word(encode(4'd7) ^ 7'b0000100, 0, 1'b1, "R9 stray input during correction");
    run_word(encode(4'd12), 0, 1'b0, "R9 next word unaffected");
  endtask

  initial begin
    t_reset();
    t_clean();
    t_single();
    t_double();
    t_gaps();
    t_junk();
    fin = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      checks++;
      errors++;
      $display("FAIL R3 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule